// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends a single byte from a host controller to a PS/2 device over the two open-drain bus lines, clock and data. The block never drives a line high. It only raises a pull-low enable for each line, and an external pull-up or pad cell turns that enable into the open-drain level. The line levels come back to the block through two bus inputs, which it synchronizes before use.

A one-cycle send request loads a byte. The block first holds the clock line low for a programmable hold-off time. It then swaps over: it releases the clock and pulls data low, which signals request-to-send. From that point the device generates every clock edge. On each device falling edge the block places the next bit on the data line: eight data bits, least significant first, then an odd parity bit. After parity it releases data so that the stop bit reads as 1. It then expects the device to hold data low at the next falling edge (the acknowledge). Once both lines are released, the transfer is complete.

Two watchdogs bound the transfer. One limits the time from acceptance to the device's first clock edge. The other limits the time from that first edge to completion. Each failure ends the transfer with its own error code, and a missing acknowledge has a third code. In every case the block returns to idle with both lines released.

Top module: `ps2_cmd_tx`

## Requirements
- R1: After reset both pull-low enables are 0, `busy`, `done` and `error` are 0, and `err_code` is 2'b00.
- R2: After a request is accepted, the block holds the clock pull-low enable at 1 and the data pull-low enable at 0 for at least INHIBIT_CYCLES clock cycles (the bench allows at most two more).
- R3: After the clock hold-off, the block releases the clock enable and raises the data enable in the same cycle. It holds that request-to-send state until the first falling edge of the synchronized device clock.
- R4: The eight data bits appear on the data line least significant bit first, one bit per device falling edge, starting at the first edge. The data enable changes only while the device holds the clock low.
- R5: The ninth bit is odd parity over the data byte, so the nine bits contain an odd number of ones. After the parity bit, the data enable is 0, so the stop bit reads as 1.
- R6: If data is low at the eleventh device falling edge, the block waits until both lines read high. It then raises `done` for one cycle, with `busy` low and `err_code` = 2'b00.
- R7: If no device falling edge arrives within START_LIMIT cycles of acceptance, the transfer ends with `err_code` = 2'b01.
- R8: If the transfer is not complete within PACKET_LIMIT cycles of the first device falling edge, it ends with `err_code` = 2'b10.
- R9: If data reads high at the eleventh device falling edge, the transfer ends with `err_code` = 2'b11.
- R10: A failed transfer raises `error` for one cycle. In that same cycle `busy` falls and both enables are 0. `err_code` keeps its value until the next request is accepted, and acceptance clears it to 2'b00.
- R11: A request is accepted only while `busy` is low, and `busy` is high in the cycle after acceptance. A request while `busy` is high changes neither the byte being sent nor the following idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| send_req | input | 1 | One-cycle request to send `send_data` |
| send_data | input | DATA_W | Byte to transmit |
| ps2_clk_in | input | 1 | Level of the bus clock line (asynchronous) |
| ps2_dat_in | input | 1 | Level of the bus data line (asynchronous) |
| ps2_clk_pull | output | 1 | 1 pulls the bus clock line low |
| ps2_dat_pull | output | 1 | 1 pulls the bus data line low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse on successful transfer |
| error | output | 1 | One-cycle pulse on a failed transfer |
| err_code | output | 2 | 00 none, 01 start timeout, 10 packet timeout, 11 no acknowledge |

## Verification
The assertions check the protocol rules on every cycle. Both enables are 0 whenever the block is idle. `busy` falls only together with `done` or `error`, and those two never coincide. The data enable changes during a transfer only while the clock line is low. `done` always carries a clear code, and `error` always carries a non-zero one. Only the bench scenarios can show the actual bit order and parity seen by a modelled device, the length of the clock hold-off, which timeout code each stalled device produces, and that a request made while busy leaves the transfer untouched.

// File: rtl/ps2_tx_pkg.sv
// Package: shared types for the PS/2 host command transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package ps2_tx_pkg;

    // Transfer phases of the transmitter
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_INHIBIT = 3'd1,
        ST_RTS     = 3'd2,
        ST_DATA    = 3'd3,
        ST_ACK     = 3'd4,
        ST_RELEASE = 3'd5
    } tx_state_t;

    // Outcome codes reported on err_code
    typedef enum logic [1:0] {
        ERR_NONE      = 2'b00,
        ERR_START_TMO = 2'b01,
        ERR_PKT_TMO   = 2'b10,
        ERR_NO_ACK    = 2'b11
    } tx_err_t;

endpackage

// File: rtl/ps2_line_sync.sv
// Module: multi-stage synchronizer with falling-edge detection for a group
// of asynchronous bus lines. Resets to 1 because an idle open-drain bus
// reads high. Assumes STAGES >= 2.
module ps2_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev;

    // Shift each line through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= din;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    // Hold the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_edge
            assign fall[g] = prev[g] & ~chain[STAGES-1][g];
        end
    endgenerate

endmodule

// File: rtl/ps2_tx_wdog.sv
// Module: cycle counter that flags expiry after LIMIT running cycles.
// Counts while run is high, saturates at LIMIT-1, and returns to zero on clr.
// Assumes LIMIT >= 2.
module ps2_tx_wdog #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;
    logic          at_last;

    assign at_last = (cnt == LAST);

    // Advance the count while running, saturating at the last value
    always_ff @(posedge clk) begin
        if (!rst_n || clr)          cnt <= '0;
        else if (run && !at_last)   cnt <= cnt + 1'b1;
    end

    assign expired = run && at_last;

endmodule

// File: rtl/ps2_cmd_tx.sv
// Module: PS/2 host-to-device byte transmitter (top).
// Takes a one-cycle send request. It holds the clock low for the hold-off
// time, then signals request-to-send. It shifts data and parity out on the
// falling edges of the device clock, then checks the acknowledge. Bus lines
// are modelled as pull-low enables, and the bus inputs are synchronized here.
// Assumes the device clock low phase is longer than SYNC_STAGES+1 cycles.
module ps2_cmd_tx
    import ps2_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int INHIBIT_CYCLES = 5000,
    parameter int START_LIMIT   = 750000,
    parameter int PACKET_LIMIT  = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_req,
    input  logic [DATA_W-1:0] send_data,
    input  logic              ps2_clk_in,
    input  logic              ps2_dat_in,
    output logic              ps2_clk_pull,
    output logic              ps2_dat_pull,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [1:0]        err_code
);

    localparam int FRAME_BITS = DATA_W + 1;               // data + parity
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS);

    tx_state_t             state;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      sent;
    logic                  dbit;
    logic [1:0]            lvl, fl;
    logic                  clk_s, dat_s, clk_fall;
    logic                  inh_exp, start_exp, pkt_exp;
    logic                  in_transfer, in_frame;

    // Synchronize both bus lines and find device clock falling edges
    ps2_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ps2_clk_in, ps2_dat_in}),
        .level (lvl),
        .fall  (fl)
    );

    assign clk_s    = lvl[1];
    assign dat_s    = lvl[0];
    assign clk_fall = fl[1];

    assign in_transfer = (state == ST_INHIBIT) || (state == ST_RTS);
    assign in_frame    = (state == ST_DATA) || (state == ST_ACK) ||
                         (state == ST_RELEASE);

    // Clock hold-off length
    ps2_tx_wdog #(.LIMIT(INHIBIT_CYCLES)) u_inh (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state == ST_INHIBIT),
        .clr     (state != ST_INHIBIT),
        .expired (inh_exp)
    );

    // Limit from acceptance to the first device clock edge
    ps2_tx_wdog #(.LIMIT(START_LIMIT)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_transfer),
        .clr     (state == ST_IDLE),
        .expired (start_exp)
    );

    // Limit from the first device clock edge to completion
    ps2_tx_wdog #(.LIMIT(PACKET_LIMIT)) u_pkt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (in_frame),
        .clr     (state == ST_IDLE),
        .expired (pkt_exp)
    );

    // Sequence the transfer and report its outcome
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '1;
            sent     <= '0;
            dbit     <= 1'b1;
            done     <= 1'b0;
            error    <= 1'b0;
            err_code <= ERR_NONE;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    dbit <= 1'b1;
                    if (send_req) begin
                        shreg    <= {~^send_data, send_data};
                        sent     <= '0;
                        err_code <= ERR_NONE;
                        state    <= ST_INHIBIT;
                    end
                end
                ST_INHIBIT: begin
                    if (start_exp) begin
                        state    <= ST_IDLE;
                        error    <= 1'b1;
                        err_code <= ERR_START_TMO;
                    end else if (inh_exp) begin
                        state <= ST_RTS;
                    end
                end
                ST_RTS: begin
                    if (clk_fall) begin
                        dbit  <= shreg[0];
                        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                        sent  <= CNT_W'(1);
                        state <= ST_DATA;
                    end else if (start_exp) begin
                        state    <= ST_IDLE;
                        error    <= 1'b1;
                        err_code <= ERR_START_TMO;
                    end
                end
                ST_DATA: begin
                    if (pkt_exp) begin
                        state    <= ST_IDLE;
                        error    <= 1'b1;
                        err_code <= ERR_PKT_TMO;
                    end else if (clk_fall) begin
                        // after the last frame bit the fill value 1 releases data
                        dbit  <= shreg[0];
                        shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                        if (sent == LAST_BIT) state <= ST_ACK;
                        else                  sent  <= sent + 1'b1;
                    end
                end
                ST_ACK: begin
                    if (pkt_exp) begin
                        state    <= ST_IDLE;
                        error    <= 1'b1;
                        err_code <= ERR_PKT_TMO;
                    end else if (clk_fall) begin
                        if (!dat_s) begin
                            state <= ST_RELEASE;
                        end else begin
                            state    <= ST_IDLE;
                            error    <= 1'b1;
                            err_code <= ERR_NO_ACK;
                        end
                    end
                end
                ST_RELEASE: begin
                    if (pkt_exp) begin
                        state    <= ST_IDLE;
                        error    <= 1'b1;
                        err_code <= ERR_PKT_TMO;
                    end else if (clk_s && dat_s) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the pull-low enables from the current phase
    always_comb begin
        ps2_clk_pull = (state == ST_INHIBIT);
        ps2_dat_pull = (state == ST_RTS) ||
                       (((state == ST_DATA) || (state == ST_ACK)) && !dbit);
    end

    assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ps2_cmd_tx_chk.sv
// Module: protocol checker for ps2_cmd_tx, attached with bind.
// Assumes the device holds the clock low longer than the synchronizer delay.
module ps2_cmd_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       send_req,
    input logic       ps2_clk_in,
    input logic       ps2_dat_in,
    input logic       ps2_clk_pull,
    input logic       ps2_dat_pull,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic [1:0] err_code
);

    // R1
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ps2_clk_pull && !ps2_dat_pull));

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && send_req) |=> busy);

    // R4
    data_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !ps2_clk_pull && $past(!ps2_clk_pull) &&
         !$stable(ps2_dat_pull)) |-> !ps2_clk_in);

    // R6
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code == 2'b00 && !busy));

    // R10
    error_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (err_code != 2'b00 && !busy));

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || error));

    // R6
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R10
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy) && !error) |-> $stable(err_code));

endmodule

bind ps2_cmd_tx ps2_cmd_tx_chk u_ps2_cmd_tx_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .send_req     (send_req),
    .ps2_clk_in   (ps2_clk_in),
    .ps2_dat_in   (ps2_dat_in),
    .ps2_clk_pull (ps2_clk_pull),
    .ps2_dat_pull (ps2_dat_pull),
    .busy         (busy),
    .done         (done),
    .error        (error),
    .err_code     (err_code)
);

// File: tb/test_ps2_cmd_tx.sv
// Bench: models a PS/2 device that clocks the frame and acknowledges it,
// with directed stalls and random bytes from a fixed seed.
module test_ps2_cmd_tx;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;     // device clock half period, in cycles
    localparam int INH        = 20;
    localparam int STL        = 300;
    localparam int PKL        = 500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       send_req = 1'b0;
    logic [7:0] send_data = 8'h00;
    logic       dev_clk = 1'b0;        // 1 = device pulls clock low
    logic       dev_dat = 1'b0;        // 1 = device pulls data low
    logic       ps2_clk_pull, ps2_dat_pull, busy, done, error;
    logic [1:0] err_code;
    wire        ps2_clk_in = ~(ps2_clk_pull | dev_clk);
    wire        ps2_dat_in = ~(ps2_dat_pull | dev_dat);

    int checks = 0;
    int fails  = 0;
    int done_seen = 0;
    int err_seen  = 0;
    logic [1:0] last_code = 2'b00;

    ps2_cmd_tx #(
        .DATA_W(8), .SYNC_STAGES(2), .INHIBIT_CYCLES(INH),
        .START_LIMIT(STL), .PACKET_LIMIT(PKL)
    ) i_ps2_cmd_tx (
        .clk(clk), .rst_n(rst_n), .send_req(send_req), .send_data(send_data),
        .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
        .ps2_clk_pull(ps2_clk_pull), .ps2_dat_pull(ps2_dat_pull),
        .busy(busy), .done(done), .error(error), .err_code(err_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record outcome pulses away from the active edge
    always @(negedge clk) begin
        if (rst_n && done) done_seen++;
        if (rst_n && error) begin
            err_seen++;
            last_code = err_code;
        end
    end

    function automatic logic odd_par(input logic [7:0] d);
        return ~^d;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // mode 0 normal, 1 device silent, 2 device stops after 4 clocks, 3 no ack
    task automatic xfer(input logic [7:0] d, input int mode, input bit poke);
        logic [9:0] got;
        int n, inh, d0, e0, dly;
        got = '0;
        d0 = done_seen;
        e0 = err_seen;
        @(negedge clk);
        send_req = 1'b1;
        send_data = d;
        @(negedge clk);
        send_req = 1'b0;
        chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
        chk(err_code == 2'b00, "R10", "code cleared on accept", err_code, 0);
        inh = 0;
        n = 0;
        while (!(ps2_dat_pull && !ps2_clk_pull) && busy && n < STL + 50) begin
            if (ps2_clk_pull && !ps2_dat_pull) inh++;
            @(negedge clk);
            n++;
        end
        if (mode == 1) begin
            while (busy && n < STL + 50) begin
                @(negedge clk);
                n++;
            end
            chk(error == 1'b1, "R10", "error pulse at end", error, 1);
            chk(err_code == 2'b01, "R7", "start timeout code", err_code, 1);
            chk(n >= STL - 3 && n <= STL + 3, "R7", "start timeout cycle", n, STL);
            chk(!ps2_clk_pull && !ps2_dat_pull, "R10", "lines released",
                ps2_clk_pull + ps2_dat_pull, 0);
            repeat (5) @(negedge clk);
            chk(err_code == 2'b01, "R10", "code held", err_code, 1);
            return;
        end
        chk(inh >= INH && inh <= INH + 2, "R2", "clock hold-off cycles", inh, INH);
        chk(!ps2_clk_pull, "R3", "clock released at request-to-send", ps2_clk_pull, 0);
        dly = 5 + int'($urandom % 26);
        repeat (dly) @(negedge clk);
        chk(ps2_dat_pull && !ps2_clk_pull, "R3", "request-to-send held",
            ps2_dat_pull, 1);
        for (int k = 1; k <= 11; k++) begin
            if (k == 11 && mode != 3) begin
                dev_dat = 1'b1;
                repeat (2) @(negedge clk);
            end
            dev_clk = 1'b1;
            repeat (HALF) @(negedge clk);
            dev_clk = 1'b0;
            repeat (HALF/2) @(negedge clk);
            if (k <= 10) got[k-1] = ps2_dat_in;
            if (poke && k == 5) begin
                send_req = 1'b1;
                send_data = ~d;
                @(negedge clk);
                send_req = 1'b0;
            end
            repeat (HALF/2) @(negedge clk);
            if (mode == 2 && k == 4) break;
        end
        dev_dat = 1'b0;
        n = 0;
        while (done_seen == d0 && err_seen == e0 && n < PKL + 100) begin
            @(negedge clk);
            n++;
        end
        repeat (2) @(negedge clk);
        chk(!ps2_clk_pull && !ps2_dat_pull && !busy, "R10", "idle after outcome",
            busy, 0);
        if (mode == 0) begin
            chk(got[7:0] == d, "R4", "data bits lsb first", got[7:0], d);
            chk(got[8] == odd_par(d), "R5", "odd parity bit", got[8], odd_par(d));
            chk(got[9] == 1'b1, "R5", "stop bit released", got[9], 1);
            chk(done_seen - d0 == 1, "R6", "single done pulse", done_seen - d0, 1);
            chk(err_seen == e0, "R6", "no error on ack", err_seen - e0, 0);
            chk(err_code == 2'b00, "R6", "code clear on done", err_code, 0);
            if (poke) begin
                repeat (60) @(negedge clk);
                chk(!busy && !ps2_clk_pull, "R11", "request while busy ignored",
                    busy, 0);
            end
        end else if (mode == 2) begin
            chk(err_seen - e0 == 1, "R8", "error pulse", err_seen - e0, 1);
            chk(last_code == 2'b10, "R8", "packet timeout code", last_code, 2);
            chk(done_seen == d0, "R8", "no done", done_seen - d0, 0);
        end else begin
            chk(got[7:0] == d, "R4", "data bits before missing ack", got[7:0], d);
            chk(got[9] == 1'b1, "R5", "stop bit released", got[9], 1);
            chk(err_seen - e0 == 1, "R9", "error pulse", err_seen - e0, 1);
            chk(last_code == 2'b11, "R9", "no-ack code", last_code, 3);
            chk(done_seen == d0, "R9", "no done", done_seen - d0, 0);
            repeat (5) @(negedge clk);
            chk(err_code == 2'b11, "R10", "code held", err_code, 3);
        end
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ps2_clk_pull, "R1", "clock enable after reset", ps2_clk_pull, 0);
        chk(!ps2_dat_pull, "R1", "data enable after reset", ps2_dat_pull, 0);
        chk(!busy && !done && !error, "R1", "flags after reset",
            busy + done + error, 0);
        chk(err_code == 2'b00, "R1", "code after reset", err_code, 0);
        xfer(8'h00, 0, 1'b0);
        xfer(8'hFF, 0, 1'b0);
        xfer(8'hA5, 0, 1'b0);
        xfer(8'h01, 0, 1'b1);
        xfer(8'h3C, 1, 1'b0);
        xfer(8'h80, 0, 1'b0);
        xfer(8'h5A, 2, 1'b0);
        xfer(8'hED, 3, 1'b0);
        xfer(8'h96, 0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            xfer(8'($urandom), 0, 1'b0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule